// File: doc/BRIEF.md
# Register-Mapped Single-Word SPI Master

The block is a serial peripheral master that a host drives through a small register port. The host picks a target device and a bus mode, then writes one word to the transmit register. That write launches a single full-duplex exchange of 8 or 16 bits. When the last bit has been clocked, the received word is held in a read-only register and a completion flag rises. The host polls the flag and clears it before the next word.

Bit timing comes from an external divider. The divider supplies a one-cycle enable pulse, and each pulse advances the serial clock by half a period. The block does not compute any rate itself. One of the chip-select lines is driven low, chosen by an index field and gated by a separate enable bit in the control register.

Top module: `spi_word_master`

## Requirements
- R1: After reset all chip-select outputs are high, the serial clock is low, and every register reads zero.
- R2: Control register (offset 0x00) bits 4:2 hold a chip-select index and bit 0 an enable. Output cs_no[index] is low only while the enable is 1, and every other chip-select stays high.
- R3: Configuration register (offset 0x04) holds clock polarity in bit 11, clock phase in bit 12 and word width in bit 5 (1 = 16 bits, 0 = 8 bits). Only these bits read back; all others read 0.
- R4: While idle, the serial clock rests at the polarity level. Each word produces exactly 2N serial clock edges, where N is the word width.
- R5: A write to the transmit register (offset 0x08) launches an exchange. Only the low N bits of the written value are sent, most significant bit first, on mosi_o.
- R6: With phase 0, miso_i is sampled on the first edge of each bit; with phase 1, on the second. The received word reads from offset 0x0C in the low N bits, with the upper bits 0.
- R7: The cause register (offset 0x10) reads 1 once an exchange completes. Writing 0 to it clears it. A non-zero write leaves it unchanged.
- R8: A transmit write that arrives while an exchange is in progress is ignored. The busy state reads back in control bit 31.
- R9: The serial clock and the shift state advance only in cycles where bit_tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| bit_tick_i | input | 1 | Half-bit enable pulse from the external divider |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 8 | Active-low chip selects |

## Verification
The bench builds the block with its defaults: eight chip selects, a 16-bit wide word and an 8-bit narrow word. These values let it reach every chip-select index and both word widths in all four clock modes. The serial input is looped back from mosi_o, optionally inverted, so that both the sampling edge and the bit order show up in the received word. A monitor on sclk_o also records the transmitted bits and counts the clock edges.

// File: rtl/spi_word_pkg.sv
package spi_word_pkg;
  localparam int REG_ADDR_W = 5;
  localparam logic [REG_ADDR_W-1:0] OFS_CTRL  = 5'h00;
  localparam logic [REG_ADDR_W-1:0] OFS_CFG   = 5'h04;
  localparam logic [REG_ADDR_W-1:0] OFS_DOUT  = 5'h08;
  localparam logic [REG_ADDR_W-1:0] OFS_DIN   = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] OFS_CAUSE = 5'h10;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_IDX_LSB  = 2;
  localparam int CTRL_BUSY_BIT = 31;
  localparam int CFG_WIDE_BIT  = 5;
  localparam int CFG_CPOL_BIT  = 11;
  localparam int CFG_CPHA_BIT  = 12;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic wide;
  } xfer_cfg_t;
endpackage

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_word_pkg::*;
#(
  parameter int NUM_CS   = 8,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int DATA_W   = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [REG_ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic                    busy_i,
  input  logic                    done_i,
  input  logic [WORD_W-1:0]       rx_word_i,
  output xfer_cfg_t               cfg_o,
  output logic [$clog2(NUM_CS)-1:0] cs_idx_o,
  output logic                    cs_en_o,
  output logic                    start_o,
  output logic [WORD_W-1:0]       tx_word_o,
  output logic                    cause_o
);
  localparam int IDX_W = $clog2(NUM_CS);

  logic [IDX_W-1:0]  idx_q;
  logic              en_q;
  xfer_cfg_t         cfg_q;
  logic [WORD_W-1:0] dout_q, din_q, wr_word;
  logic              cause_q;
  logic              wr_ctrl, wr_cfg, wr_dout, wr_cause;

  assign wr_ctrl  = we_i && (addr_i == OFS_CTRL);
  assign wr_cfg   = we_i && (addr_i == OFS_CFG);
  assign wr_dout  = we_i && (addr_i == OFS_DOUT);
  assign wr_cause = we_i && (addr_i == OFS_CAUSE);

  // width follows the live config bit at the time of the write
  assign wr_word  = cfg_q.wide ? wdata_i[WORD_W-1:0] : WORD_W'(wdata_i[NARROW_W-1:0]);
  assign start_o  = wr_dout && !busy_i;
  assign tx_word_o = wr_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      en_q    <= 1'b0;
      cfg_q   <= '0;
      dout_q  <= '0;
      din_q   <= '0;
      cause_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[CTRL_EN_BIT];
        idx_q <= wdata_i[CTRL_IDX_LSB +: IDX_W];
      end
      if (wr_cfg) begin
        cfg_q.cpol <= wdata_i[CFG_CPOL_BIT];
        cfg_q.cpha <= wdata_i[CFG_CPHA_BIT];
        cfg_q.wide <= wdata_i[CFG_WIDE_BIT];
      end
      if (start_o) dout_q <= wr_word;
      if (done_i) din_q <= rx_word_i;
      if (done_i) cause_q <= 1'b1;
      else if (wr_cause && (wdata_i == '0)) cause_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL: begin
        rdata_o[CTRL_EN_BIT]                = en_q;
        rdata_o[CTRL_IDX_LSB +: IDX_W]      = idx_q;
        rdata_o[CTRL_BUSY_BIT]              = busy_i;
      end
      OFS_CFG: begin
        rdata_o[CFG_CPOL_BIT] = cfg_q.cpol;
        rdata_o[CFG_CPHA_BIT] = cfg_q.cpha;
        rdata_o[CFG_WIDE_BIT] = cfg_q.wide;
      end
      OFS_DOUT:  rdata_o[WORD_W-1:0] = dout_q;
      OFS_DIN:   rdata_o[WORD_W-1:0] = din_q;
      OFS_CAUSE: rdata_o[0]          = cause_q;
      default:   rdata_o = '0;
    endcase
  end

  assign cfg_o    = cfg_q;
  assign cs_idx_o = idx_q;
  assign cs_en_o  = en_q;
  assign cause_o  = cause_q;
endmodule

// File: rtl/spi_cs_steer.sv
module spi_cs_steer #(
  parameter int NUM_CS = 8
) (
  input  logic [$clog2(NUM_CS)-1:0] idx_i,
  input  logic                      en_i,
  output logic [NUM_CS-1:0]         cs_no
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(en_i && (idx_i == g[$clog2(NUM_CS)-1:0]));
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_word_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  xfer_cfg_t         cfg_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_o,
  output logic              sclk_o,
  output logic              mosi_o
);
  localparam int CNT_W = $clog2(2 * WORD_W);
  localparam int PAD_W = WORD_W - NARROW_W;
  localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(2 * WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(2 * NARROW_W - 1);

  logic              busy_q, phase_q, cpol_q, cpha_q, wide_q;
  logic [CNT_W-1:0]  edge_q, last_edge;
  logic [WORD_W-1:0] tx_sr, rx_sr, rx_next;
  logic              step, sample, last;

  assign last_edge = wide_q ? LAST_WIDE : LAST_NARROW;
  // even edge index = leading edge of a bit
  assign sample  = (~edge_q[0]) ^ cpha_q;
  assign rx_next = {rx_sr[WORD_W-2:0], miso_i};
  assign step    = busy_q && tick_i;
  assign last    = step && (edge_q == last_edge);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      wide_q  <= 1'b0;
      edge_q  <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      phase_q <= 1'b0;
      edge_q  <= '0;
      cpol_q  <= cfg_i.cpol;
      cpha_q  <= cfg_i.cpha;
      wide_q  <= cfg_i.wide;
      tx_sr   <= cfg_i.wide ? word_i : (word_i << PAD_W);
      rx_sr   <= '0;
    end else if (step) begin
      phase_q <= ~phase_q;
      edge_q  <= edge_q + 1'b1;
      if (sample) rx_sr <= rx_next;
      else if (edge_q != '0) tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
      if (last) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = last;
  assign rx_o   = sample ? rx_next : rx_sr;
  assign sclk_o = busy_q ? (cpol_q ^ phase_q) : cfg_i.cpol;
  assign mosi_o = tx_sr[WORD_W-1];
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_word_pkg::*;
#(
  parameter int NUM_CS   = 8,
  parameter int WORD_W   = 16,
  parameter int NARROW_W = 8,
  parameter int DATA_W   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic                  bit_tick_i,
  output logic                  sclk_o,
  output logic                  mosi_o,
  input  logic                  miso_i,
  output logic [NUM_CS-1:0]     cs_no
);
  localparam int IDX_W = $clog2(NUM_CS);

  xfer_cfg_t         cfg;
  logic [IDX_W-1:0]  cs_idx;
  logic              cs_en, start, busy, done, cause;
  logic [WORD_W-1:0] tx_word, rx_word;

  spi_reg_bank #(
    .NUM_CS(NUM_CS), .WORD_W(WORD_W), .NARROW_W(NARROW_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .done_i(done), .rx_word_i(rx_word),
    .cfg_o(cfg), .cs_idx_o(cs_idx), .cs_en_o(cs_en),
    .start_o(start), .tx_word_o(tx_word), .cause_o(cause)
  );

  spi_cs_steer #(.NUM_CS(NUM_CS)) u_cs (
    .idx_i(cs_idx), .en_i(cs_en), .cs_no(cs_no)
  );

  spi_shift_engine #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_eng (
    .clk_i, .rst_ni,
    .start_i(start), .word_i(tx_word), .cfg_i(cfg), .tick_i(bit_tick_i),
    .miso_i(miso_i), .busy_o(busy), .done_o(done), .rx_o(rx_word),
    .sclk_o(sclk_o), .mosi_o(mosi_o)
  );
endmodule

module spi_word_master_chk
  import spi_word_pkg::*;
#(
  parameter int NUM_CS = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  busy_i,
  input logic                  tick_i,
  input logic                  sclk_i,
  input logic                  mosi_i,
  input logic [NUM_CS-1:0]     cs_ni,
  input logic                  cs_en_i,
  input logic                  cpol_i,
  input logic                  cause_i,
  input logic                  we_i,
  input logic [REG_ADDR_W-1:0] addr_i
);
  logic dout_wr;
  assign dout_wr = we_i && (addr_i == OFS_DOUT);

  // R2
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(~cs_ni));
  // R2
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !cs_en_i |-> (&cs_ni));
  // R4
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !busy_i |-> (sclk_i == cpol_i));
  // R9
  sclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (busy_i && !tick_i) |=> $stable(sclk_i));
  // R7
  cause_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(cause_i) |-> $past(busy_i));
  // R8
  mosi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (busy_i && dout_wr && !tick_i) |=> $stable(mosi_i));
endmodule

bind spi_word_master spi_word_master_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .tick_i(bit_tick_i),
  .sclk_i(sclk_o), .mosi_i(mosi_o), .cs_ni(cs_no), .cs_en_i(cs_en),
  .cpol_i(cfg.cpol), .cause_i(cause), .we_i(reg_we_i), .addr_i(reg_addr_i)
);

// File: tb/spi_word_master_tb.sv
`timescale 1ns/1ps
module spi_word_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick = 1'b0;
  logic        tick_en = 1'b1;
  logic        sclk, mosi, miso;
  logic [7:0]  cs_n;
  logic        miso_inv = 1'b0;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  logic        cur_cpol = 1'b0, cur_cpha = 1'b0, prev_sclk = 1'b0;
  int          edges = 0;
  logic [15:0] cap = '0;

  always #2.5 clk = ~clk;
  assign miso = mosi ^ miso_inv;

  spi_word_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .bit_tick_i(tick),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  // {cpol, cpha, wide, idx[2:0], tx[15:0], invert}
  localparam logic [22:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 3'd0, 16'h00A5, 1'b0},
    {1'b0, 1'b1, 1'b0, 3'd3, 16'h003C, 1'b1},
    {1'b1, 1'b0, 1'b0, 3'd5, 16'h0081, 1'b0},
    {1'b1, 1'b1, 1'b0, 3'd7, 16'h00FE, 1'b1},
    {1'b0, 1'b0, 1'b1, 3'd1, 16'hBEEF, 1'b0},
    {1'b1, 1'b1, 1'b1, 3'd2, 16'h8001, 1'b1},
    {1'b0, 1'b1, 1'b1, 3'd4, 16'h1234, 1'b0},
    {1'b1, 1'b0, 1'b1, 3'd6, 16'hC3A5, 1'b1}
  };

  initial begin
    int div = 0;
    forever begin
      @(negedge clk);
      tick = tick_en && (div == 2);
      div = (div == 2) ? 0 : div + 1;
    end
  end

  // serial monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (sclk !== prev_sclk) begin
      edges++;
      if (((sclk != cur_cpol) ^ cur_cpha) == 1'b1) cap = {cap[14:0], mosi};
    end
    prev_sclk = sclk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(5'h10, v);
      if (v != 0) break;
    end
  endtask

  task automatic setup(input logic cpol, input logic cpha, input logic wide, input logic [2:0] idx);
    wr(5'h04, (32'(cpha) << 12) | (32'(cpol) << 11) | (32'(wide) << 5));
    wr(5'h00, (32'(idx) << 2) | 32'h1);
    cur_cpol = cpol; cur_cpha = cpha;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 cs", {24'h0, cs_n}, 32'hFF);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);
    rd(5'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(5'h10, v); chk("R1 cause", v, 32'h0);
    rd(5'h0C, v); chk("R1 din", v, 32'h0);

    // R3 only the mode bits are stored
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R3 cfg readback", v, 32'h0000_1820);
    @(negedge clk);
    chk("R4 idle at cpol=1", {31'h0, sclk}, 32'h1);
    wr(5'h04, 32'h0);

    for (int i = 0; i < 8; i++) begin
      logic [22:0] e;
      logic [15:0] mask, tx, exp_rx;
      int n;
      e = VEC[i];
      n = e[20] ? 16 : 8;
      mask = e[20] ? 16'hFFFF : 16'h00FF;
      tx = e[16:1];
      exp_rx = (e[0] ? ~tx : tx) & mask;
      setup(e[22], e[21], e[20], e[19:17]);
      miso_inv = e[0];
      chk("R2 cs select", {24'h0, cs_n}, {24'h0, ~(8'h1 << e[19:17])});
      chk("R4 idle level", {31'h0, sclk}, {31'h0, e[22]});
      wr(5'h10, 32'h0);
      edges = 0; cap = '0;
      wr(5'h08, {16'hDEAD, tx});
      wait_done();
      chk("R5 mosi msb first", {16'h0, cap & mask}, {16'h0, tx & mask});
      chk("R4 edge count", edges, 2 * n);
      rd(5'h0C, v); chk("R6 din", v, {16'h0, exp_rx});
      rd(5'h10, v); chk("R7 cause set", v, 32'h1);
      rd(5'h00, v); chk("R8 busy clear", {31'h0, v[31]}, 32'h0);
      chk("R4 returns idle", {31'h0, sclk}, {31'h0, e[22]});
      wr(5'h00, 32'(e[19:17]) << 2);
      chk("R2 deassert", {24'h0, cs_n}, 32'hFF);
    end

    // R7 clear semantics
    wr(5'h10, 32'h1);
    rd(5'h10, v); chk("R7 nonzero write keeps", v, 32'h1);
    wr(5'h10, 32'h0);
    rd(5'h10, v); chk("R7 zero write clears", v, 32'h0);
    wr(5'h10, 32'h2);
    rd(5'h10, v); chk("R7 nonzero write no set", v, 32'h0);

    // R8 write during busy ignored
    setup(1'b0, 1'b0, 1'b0, 3'd2);
    miso_inv = 1'b0;
    edges = 0; cap = '0;
    wr(5'h08, 32'h33);
    wr(5'h08, 32'hCC);
    rd(5'h00, v); chk("R8 busy readback", {31'h0, v[31]}, 32'h1);
    wait_done();
    rd(5'h0C, v); chk("R8 din keeps first word", v, 32'h33);
    chk("R8 mosi first word", {16'h0, cap}, 32'h33);
    rd(5'h08, v); chk("R8 dout keeps first word", v, 32'h33);
    chk("R8 edge count", edges, 16);

    // R9 no tick, no progress
    wr(5'h10, 32'h0);
    wr(5'h08, 32'h5A);
    repeat (7) @(negedge clk);
    tick_en = 1'b0;
    repeat (2) @(negedge clk);
    begin
      logic s0;
      int e0;
      s0 = sclk; e0 = edges;
      repeat (20) @(negedge clk);
      chk("R9 sclk held", {31'h0, sclk}, {31'h0, s0});
      chk("R9 no edges", edges, e0);
    end
    rd(5'h00, v); chk("R9 still busy", {31'h0, v[31]}, 32'h1);
    tick_en = 1'b1;
    wait_done();
    rd(5'h0C, v); chk("R9 resumes to completion", v, 32'h5A);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule